// File: doc/BRIEF.md
# Loop-aware branch condition evaluator

This block decides whether a conditional control transfer is taken. A 4-bit condition type selects how the selected predicate bit and a hardware loop-end indication are combined. The loop-end indication is derived from an external epilogue counter and from a loop status register that the block holds. The low 32 bits of that register are the loop counter. The taken flag is purely combinational, so it is ready in the same cycle as its inputs.

On a commit strobe, two enables choose whether the loop counter is decremented. One enable acts when the branch is taken and the other acts when it is not. The decrement stops at zero and leaves the upper status bits untouched. A load port writes the whole status register, for example at loop setup. Condition types outside the supported set are reported as unsupported and are never taken.

Top module: `loop_branch_eval`

## Requirements
- R1: After reset, the status register output `lsr_o` is all zeros.
- R2: Condition type 1 gives `taken_o` = 1 whatever the predicate and the loop state are.
- R3: Type 2 gives `taken_o` equal to `pred_i`. Type 3 gives `taken_o` equal to the inverse of `pred_i`.
- R4: Loop end is true exactly when three conditions hold: `ecnt_i` is 0, the loop counter (`lsr_o[31:0]`) is below 2, and the valid bit `lsr_o[37]` is 1. Type 4 is taken exactly at loop end, and type 5 exactly when not at loop end.
- R5: Type 6 is taken on `pred_i` OR loop end. Type 14 is taken on NOT `pred_i` OR loop end. Type 7 is taken on NOT `pred_i` AND NOT loop end. Type 15 is taken on `pred_i` AND NOT loop end.
- R6: Any type other than 1–7, 14 and 15 gives `taken_o` = 0 and `unsupported_o` = 1. Every listed type gives `unsupported_o` = 0.
- R7: On a clock edge with `commit_i` = 1, the loop counter is decremented in two cases: `dec_on_taken_i` is 1 and the branch is taken, or `dec_on_not_taken_i` is 1 and it is not taken. Otherwise `lsr_o` is unchanged.
- R8: A decrement applied to a loop counter of 0 leaves it at 0.
- R9: A decrement never changes `lsr_o[63:32]`.
- R10: `lsr_load_i` writes `lsr_wdata_i` into the status register on the next edge and takes priority over a commit in the same cycle.
- R11: `taken_o` follows its inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_type_i | input | 4 | Condition type |
| pred_i | input | 1 | Selected predicate value |
| ecnt_i | input | 8 | Epilogue counter value |
| commit_i | input | 1 | Commit strobe for the loop counter update |
| dec_on_taken_i | input | 1 | Decrement enable when taken |
| dec_on_not_taken_i | input | 1 | Decrement enable when not taken |
| lsr_load_i | input | 1 | Status register write |
| lsr_wdata_i | input | 64 | Status register write data |
| taken_o | output | 1 | Branch taken flag |
| unsupported_o | output | 1 | Condition type not supported |
| lsr_o | output | 64 | Loop status register |

## Verification
The assertions check several properties on every cycle:
- an unsupported type is never taken;
- type 1 is always taken;
- types 4 and 5 agree with the loop-end detector;
- the counter does not wrap below zero;
- the upper status bits move only on a load;
- the register holds when it is neither loaded nor committed.

Only the bench scenarios can show the rest. These are the exact truth table of every type against predicate and loop state, the three-way loop-end condition at its boundaries, the choice between the two decrement enables, and load priority.

// File: rtl/lbe_pkg.sv
package lbe_pkg;
  localparam int unsigned CT_W = 4;

  typedef enum logic [CT_W-1:0] {
    CT_ALWAYS        = 4'd1,
    CT_PRED          = 4'd2,
    CT_NPRED         = 4'd3,
    CT_LEND          = 4'd4,
    CT_NLEND         = 4'd5,
    CT_PRED_OR_LE    = 4'd6,
    CT_NPRED_AND_NLE = 4'd7,
    CT_NPRED_OR_LE   = 4'd14,
    CT_PRED_AND_NLE  = 4'd15
  } ctype_e;
endpackage

// File: rtl/lbe_loop_end.sv
module lbe_loop_end #(
  parameter int unsigned LSR_W   = 64,
  parameter int unsigned LCNT_W  = 32,
  parameter int unsigned ECNT_W  = 8,
  parameter int unsigned VLD_BIT = 37
) (
  input  logic [ECNT_W-1:0] ecnt_i,
  input  logic [LSR_W-1:0]  lsr_i,
  output logic              loop_end_o
);
  localparam logic [LCNT_W-1:0] LCNT_LIM = LCNT_W'(2);

  logic ecnt_zero, lcnt_last, vld;

  always_comb begin
    ecnt_zero  = (ecnt_i == '0);
    lcnt_last  = (lsr_i[LCNT_W-1:0] < LCNT_LIM);
    vld        = lsr_i[VLD_BIT];
    loop_end_o = ecnt_zero & lcnt_last & vld;
  end
endmodule

// File: rtl/lbe_cond_eval.sv
module lbe_cond_eval
  import lbe_pkg::*;
(
  input  logic [CT_W-1:0] cond_type_i,
  input  logic            pred_i,
  input  logic            loop_end_i,
  output logic            taken_o,
  output logic            unsup_o
);
  logic pterm;

  always_comb begin
    unsup_o = 1'b0;
    // predicate polarity, then merged with loop end
    pterm   = (cond_type_i == CT_NPRED) || (cond_type_i == CT_NPRED_AND_NLE) ||
              (cond_type_i == CT_NPRED_OR_LE) ? ~pred_i : pred_i;
    case (cond_type_i)
      CT_ALWAYS:                   taken_o = 1'b1;
      CT_PRED, CT_NPRED:           taken_o = pterm;
      CT_LEND:                     taken_o = loop_end_i;
      CT_NLEND:                    taken_o = ~loop_end_i;
      CT_PRED_OR_LE,
      CT_NPRED_OR_LE:              taken_o = pterm | loop_end_i;
      CT_NPRED_AND_NLE,
      CT_PRED_AND_NLE:             taken_o = pterm & ~loop_end_i;
      default: begin
        taken_o = 1'b0;
        unsup_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lbe_lsr.sv
module lbe_lsr #(
  parameter int unsigned LSR_W  = 64,
  parameter int unsigned LCNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LSR_W-1:0] wdata_i,
  input  logic             commit_i,
  input  logic             dec_i,
  output logic [LSR_W-1:0] lsr_o
);
  localparam int unsigned HI_W = LSR_W - LCNT_W;

  logic [LSR_W-1:0]  lsr_q;
  logic [LCNT_W-1:0] lcnt_nxt;

  always_comb begin
    lcnt_nxt = lsr_q[LCNT_W-1:0];
    if (dec_i && lsr_q[LCNT_W-1:0] != '0) lcnt_nxt = lsr_q[LCNT_W-1:0] - LCNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lsr_q <= '0;
    else if (load_i)            lsr_q <= wdata_i;
    else if (commit_i && dec_i) lsr_q <= {lsr_q[LSR_W-1:LCNT_W], lcnt_nxt};
  end

  assign lsr_o = lsr_q;

  AST_LCNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && lsr_q[LCNT_W-1:0] == '0) |=> (lsr_q[LCNT_W-1:0] == '0)); // R8
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lsr_q[LSR_W-1:LSR_W-HI_W])); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !commit_i) |=> $stable(lsr_q)); // R7
endmodule

// File: rtl/loop_branch_eval.sv
module loop_branch_eval
  import lbe_pkg::*;
#(
  parameter int unsigned LSR_W   = 64,
  parameter int unsigned LCNT_W  = 32,
  parameter int unsigned ECNT_W  = 8,
  parameter int unsigned VLD_BIT = 37
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CT_W-1:0]   cond_type_i,
  input  logic              pred_i,
  input  logic [ECNT_W-1:0] ecnt_i,
  input  logic              commit_i,
  input  logic              dec_on_taken_i,
  input  logic              dec_on_not_taken_i,
  input  logic              lsr_load_i,
  input  logic [LSR_W-1:0]  lsr_wdata_i,
  output logic              taken_o,
  output logic              unsupported_o,
  output logic [LSR_W-1:0]  lsr_o
);
  logic [LSR_W-1:0] lsr_q;
  logic             loop_end;
  logic             dec_sel;

  lbe_loop_end #(
    .LSR_W(LSR_W), .LCNT_W(LCNT_W), .ECNT_W(ECNT_W), .VLD_BIT(VLD_BIT)
  ) u_loop_end (
    .ecnt_i    (ecnt_i),
    .lsr_i     (lsr_q),
    .loop_end_o(loop_end)
  );

  lbe_cond_eval u_cond (
    .cond_type_i(cond_type_i),
    .pred_i     (pred_i),
    .loop_end_i (loop_end),
    .taken_o    (taken_o),
    .unsup_o    (unsupported_o)
  );

  assign dec_sel = (dec_on_taken_i & taken_o) | (dec_on_not_taken_i & ~taken_o);

  lbe_lsr #(.LSR_W(LSR_W), .LCNT_W(LCNT_W)) u_lsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lsr_load_i),
    .wdata_i (lsr_wdata_i),
    .commit_i(commit_i),
    .dec_i   (dec_sel),
    .lsr_o   (lsr_q)
  );

  assign lsr_o = lsr_q;

  AST_UNSUP_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> !taken_o); // R6
  AST_UNCOND_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_type_i == CT_ALWAYS) |-> taken_o); // R2
  AST_LEND_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_type_i == CT_LEND) |-> (taken_o == loop_end)); // R4
  AST_NLEND_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_type_i == CT_NLEND) |-> (taken_o != loop_end)); // R4
endmodule

// File: tb/loop_branch_eval_bench.sv
module loop_branch_eval_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  cond_type_i = '0;
  logic        pred_i = 1'b0;
  logic [7:0]  ecnt_i = '0;
  logic        commit_i = 1'b0;
  logic        dec_on_taken_i = 1'b0;
  logic        dec_on_not_taken_i = 1'b0;
  logic        lsr_load_i = 1'b0;
  logic [63:0] lsr_wdata_i = '0;
  logic        taken_o, unsupported_o;
  logic [63:0] lsr_o;

  int n_run = 0, n_fail = 0;
  logic [63:0] m_lsr = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  loop_branch_eval u_loop_branch_eval (.*);

  function automatic logic f_lend(logic [7:0] e, logic [63:0] l);
    return (e == 0) && (l[31:0] < 2) && l[37];
  endfunction

  function automatic logic f_taken(logic [3:0] t, logic p, logic le, output logic us);
    us = 1'b0;
    case (t)
      4'd1: return 1'b1;
      4'd2: return p;
      4'd3: return !p;
      4'd4: return le;
      4'd5: return !le;
      4'd6: return p | le;
      4'd7: return !p & !le;
      4'd14: return !p | le;
      4'd15: return p & !le;
      default: begin us = 1'b1; return 1'b0; end
    endcase
  endfunction

  function automatic string f_req(logic [3:0] t);
    case (t)
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7, 4'd14, 4'd15: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one cycle: apply at negedge, check comb, check register after edge
  task automatic step(logic [3:0] t, logic p, logic [7:0] e, logic cm, logic dt,
                      logic dn, logic ld, logic [63:0] wd);
    logic us, tk;
    logic [63:0] nxt;
    @(negedge clk_i);
    cond_type_i = t; pred_i = p; ecnt_i = e; commit_i = cm;
    dec_on_taken_i = dt; dec_on_not_taken_i = dn; lsr_load_i = ld; lsr_wdata_i = wd;
    #1;
    tk = f_taken(t, p, f_lend(e, m_lsr), us);
    chk({f_req(t), " R11 taken"}, {63'd0, taken_o}, {63'd0, tk});
    chk("R6 unsupported", {63'd0, unsupported_o}, {63'd0, us});
    nxt = m_lsr;
    if (ld) nxt = wd;
    else if (cm && ((dt && tk) || (dn && !tk)) && m_lsr[31:0] != 0)
      nxt[31:0] = m_lsr[31:0] - 1;
    @(posedge clk_i); #1;
    chk((m_lsr[31:0] == 0 && !ld) ? "R8 lcnt" : (ld ? "R10 lsr" : "R7 lsr"),
        {32'd0, lsr_o[31:0]}, {32'd0, nxt[31:0]});
    chk(ld ? "R10 upper" : "R9 upper", {32'd0, lsr_o[63:32]}, {32'd0, nxt[63:32]});
    m_lsr = nxt;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_fail++;
    $display("FAIL watchdog act=hang exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2); #1;
    chk("R1 reset", lsr_o, 64'd0);
    rst_ni = 1'b1;
    // directed: R4 loop end boundaries, valid bit 37
    step(4'd1, 0, 8'd3, 0, 0, 0, 1, 64'h0000_0020_0000_0001);
    step(4'd4, 0, 8'd0, 0, 0, 0, 0, 0);           // lcnt=1, valid -> loop end
    step(4'd4, 0, 8'd1, 0, 0, 0, 0, 0);           // ecnt!=0
    step(4'd5, 0, 8'd0, 0, 0, 0, 0, 0);
    step(4'd1, 0, 8'd0, 0, 0, 0, 1, 64'h0000_0020_0000_0002);
    step(4'd4, 1, 8'd0, 0, 0, 0, 0, 0);           // lcnt=2 -> not loop end
    step(4'd1, 0, 8'd0, 0, 0, 0, 1, 64'h0000_0000_0000_0000);
    step(4'd4, 1, 8'd0, 0, 0, 0, 0, 0);           // valid clear
    // R8 saturation, R7 both enables
    step(4'd1, 0, 8'd0, 1, 1, 0, 0, 0);
    step(4'd1, 0, 8'd0, 0, 0, 0, 1, 64'hFFFF_FFFF_0000_0003);
    step(4'd2, 0, 8'd0, 1, 1, 0, 0, 0);           // not taken, dt only: hold
    step(4'd2, 0, 8'd0, 1, 0, 1, 0, 0);           // decrement
    step(4'd2, 1, 8'd0, 0, 1, 1, 0, 0);           // no commit: hold
    // R10 load beats commit
    step(4'd1, 0, 8'd0, 1, 1, 1, 1, 64'h1234_5678_0000_0009);
    // R6 unlisted types
    for (int t = 0; t < 16; t++) step(4'(t), 1'($urandom), 8'($urandom_range(0, 1)), 0, 0, 0, 0, 0);
    // random
    for (int i = 0; i < 600; i++) begin
      logic [63:0] wd;
      wd = {$urandom, 32'($urandom_range(0, 3))};
      wd[37] = 1'($urandom);
      step(4'($urandom), 1'($urandom), 8'($urandom_range(0, 2)), 1'($urandom),
           1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), wd);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule